// File: doc/BRIEF.md
# Bimodal Branch Predictor with Tagged Target Buffer

This block sits at the fetch stage and predicts, in the same cycle a fetch address is presented, whether the instruction there is a taken branch and which address to fetch next. It keeps one saturating direction counter per table slot. The slot is chosen by low bits of the fetch address above the byte offset. Next to the counters sits an optional tagged target store. It records the last taken target for each slot, together with the upper address bits that identify the branch that owns the slot.

The selection rule for the next fetch address is simple. It is the stored target when the target store hits and the counter predicts taken, and the fall-through address (fetch address plus 4) in every other case. A resolve port, driven from the stage where branches are executed, presents the branch address, its real outcome and its real target. At the next clock edge this moves the counter one step or seeds a new slot.

For the default 2-bit width, each counter is a four-state machine: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken resolve moves it one state up (STRONG_NT→WEAK_NT→WEAK_T→STRONG_T, and STRONG_T holds). A not-taken resolve moves it one state down (STRONG_T→WEAK_T→WEAK_NT→STRONG_NT, and STRONG_NT holds). A third transition, ALLOC, forces WEAK_T when a taken branch misses in the target store. The per-update action is one of IDLE, INC, DEC or ALLOC.

Top module: `bimodal_btb_predictor`

## Requirements
- R1: `pred_taken` is 1 exactly when the counter of the slot selected by `fetch_pc` is at least 2^(CTR_W-1). With CTR_W=2, values 00 and 01 give 0, and 10 and 11 give 1. `pred_taken` does not depend on the tag comparison.
- R2: A resolve that does not allocate adds one to the counter of its slot when `upd_taken` is 1, and subtracts one when it is 0. The counter holds at all ones on a taken resolve and holds at zero on a not-taken resolve.
- R3: For a slot whose target store entry hits, a counter at 00 needs two taken resolves before `pred_taken` becomes 1. A counter at 11 still predicts taken after one not-taken resolve.
- R4: The slot index is `pc[IDX_W+1:2]` and the tag is `pc[PC_W-1:IDX_W+2]`, with IDX_W = log2(ENTRIES). `pred_hit` is 1 when the slot's entry is valid and its stored tag equals the fetch tag. The counters carry no tag, so addresses with the same index share one counter.
- R5: `pred_next_pc` equals the stored target when `pred_hit` and `pred_taken` are both 1. Otherwise it equals `fetch_pc + 4`, modulo 2^PC_W.
- R6: After reset every counter is 01 (value 2^(CTR_W-1)-1) and every target store entry is invalid, so `pred_hit` is 0 for all addresses.
- R7: A taken resolve that misses in the target store writes the new tag and target into the slot, marks it valid and sets the counter to 10 (2^(CTR_W-1)). A not-taken resolve that misses allocates nothing. A taken resolve that hits overwrites the stored target with `upd_target`. A not-taken resolve that hits keeps the stored target.
- R8: When a fetch and a resolve select the same slot in one cycle, the fetch outputs reflect the contents before the resolve. The new contents are visible from the next cycle on.
- R9: While `upd_valid` is 0, the counters and the target store do not change, whatever `upd_pc`, `upd_taken` and `upd_target` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Target store holds a valid entry whose tag matches `fetch_pc` |
| pred_taken | output | 1 | Direction counter of the slot predicts taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | PC_W | Resolved target of the branch |

## Verification
The bench builds the predictor with PC_W=16, ENTRIES=8, CTR_W=2 and HAS_BTB=1. With only eight slots, two tag values per slot cover every slot in every sweep step. They also make tag aliasing on a shared counter occur often. The 16-bit address places the fall-through wrap at 0xFFFC within easy reach. A long pseudo-random resolve stream, with directed walks through all four counter states, drives every saturation edge and every allocation and refresh case. It also drives the same-cycle read-during-update case.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Action applied to one table slot by a resolved branch.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_DEC   = 2'd2,
        ACT_ALLOC = 2'd3
    } bp_action_e;

endpackage

// File: rtl/bp_update_ctl.sv
module bp_update_ctl
    import bp_pkg::*;
#(
    parameter bit ALLOC_EN = 1'b1
) (
    input  logic       upd_valid,
    input  logic       upd_hit,
    input  logic       upd_taken,
    output bp_action_e action
);

    always_comb begin
        action = ACT_IDLE;
        unique case ({upd_valid, upd_hit, upd_taken})
            3'b111:  action = ACT_INC;
            3'b110:  action = ACT_DEC;
            3'b101:  action = ALLOC_EN ? ACT_ALLOC : ACT_INC;
            3'b100:  action = ACT_DEC;
            default: action = ACT_IDLE;
        endcase
    end

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int CTR_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic [IDX_W-1:0] upd_idx,
    output logic [CTR_W-1:0] upd_ctr,
    input  bp_action_e       action
);

    localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_ZERO = '0;
    localparam logic [CTR_W-1:0] WEAK_T   = CTR_W'(1) << (CTR_W - 1);
    localparam logic [CTR_W-1:0] WEAK_NT  = WEAK_T - CTR_W'(1);

    logic [CTR_W-1:0] ctr_q [ENTRIES];
    logic [CTR_W-1:0] ctr_next;

    assign rd_ctr  = ctr_q[rd_idx];
    assign upd_ctr = ctr_q[upd_idx];

    always_comb begin
        ctr_next = upd_ctr;
        unique case (action)
            ACT_INC:   ctr_next = (upd_ctr == CTR_MAX)  ? upd_ctr : upd_ctr + CTR_W'(1);
            ACT_DEC:   ctr_next = (upd_ctr == CTR_ZERO) ? upd_ctr : upd_ctr - CTR_W'(1);
            ACT_ALLOC: ctr_next = WEAK_T;
            ACT_IDLE:  ctr_next = upd_ctr;
            default:   ctr_next = upd_ctr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= WEAK_NT;
            end
        end else if (action != ACT_IDLE) begin
            ctr_q[upd_idx] <= ctr_next;
        end
    end

endmodule

// File: rtl/bp_target_store.sv
module bp_target_store #(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    parameter bit PRESENT = 1'b1,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    output logic             upd_hit,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_target
);

    generate
        if (PRESENT) begin : g_store
            logic             valid_q  [ENTRIES];
            logic [TAG_W-1:0] tag_q    [ENTRIES];
            logic [PC_W-1:0]  target_q [ENTRIES];

            assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
            assign rd_target = target_q[rd_idx];
            assign upd_hit   = valid_q[upd_idx] && (tag_q[upd_idx] == upd_tag);

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        valid_q[i] <= 1'b0;
                    end
                end else if (wr_en) begin
                    valid_q[upd_idx] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst && wr_en) begin
                    tag_q[upd_idx]    <= upd_tag;
                    target_q[upd_idx] <= wr_target;
                end
            end
        end else begin : g_none
            logic unused_store;
            assign unused_store = ^{clk, rst, rd_idx, rd_tag, upd_idx, upd_tag, wr_en, wr_target};
            assign rd_hit    = 1'b0;
            assign rd_target = '0;
            assign upd_hit   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bp_next_sel.sv
module bp_next_sel #(
    parameter int PC_W = 32
) (
    input  logic            hit,
    input  logic            taken,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] next_pc
);

    logic [PC_W-1:0] fall_through;

    assign fall_through = pc + PC_W'(4);

    always_comb begin
        unique case ({hit, taken})
            2'b11:   next_pc = target;
            default: next_pc = fall_through;
        endcase
    end

endmodule

// File: rtl/bimodal_btb_predictor.sv
module bimodal_btb_predictor
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int CTR_W   = 2,
    parameter bit HAS_BTB = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam logic [CTR_W-1:0] TAKEN_MIN = CTR_W'(1) << (CTR_W - 1);

    logic [IDX_W-1:0] fetch_idx;
    logic [TAG_W-1:0] fetch_tag;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;
    logic [CTR_W-1:0] fetch_ctr;
    logic [CTR_W-1:0] upd_ctr;
    logic [PC_W-1:0]  target_rd;
    logic             upd_hit;
    logic             tgt_wr;
    bp_action_e       action;
    logic             unused_low;

    assign fetch_idx  = fetch_pc[IDX_W+1:2];
    assign fetch_tag  = fetch_pc[PC_W-1:IDX_W+2];
    assign upd_idx    = upd_pc[IDX_W+1:2];
    assign upd_tag    = upd_pc[PC_W-1:IDX_W+2];
    assign unused_low = ^upd_pc[1:0];

    assign pred_taken = (fetch_ctr >= TAKEN_MIN);
    assign tgt_wr     = upd_valid && upd_taken;

    bp_update_ctl #(
        .ALLOC_EN (HAS_BTB)
    ) u_ctl (
        .upd_valid (upd_valid),
        .upd_hit   (upd_hit),
        .upd_taken (upd_taken),
        .action    (action)
    );

    bp_counter_table #(
        .ENTRIES (ENTRIES),
        .CTR_W   (CTR_W)
    ) u_ctrs (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fetch_idx),
        .rd_ctr  (fetch_ctr),
        .upd_idx (upd_idx),
        .upd_ctr (upd_ctr),
        .action  (action)
    );

    bp_target_store #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W),
        .PRESENT (HAS_BTB)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (fetch_idx),
        .rd_tag    (fetch_tag),
        .rd_hit    (pred_hit),
        .rd_target (target_rd),
        .upd_idx   (upd_idx),
        .upd_tag   (upd_tag),
        .upd_hit   (upd_hit),
        .wr_en     (tgt_wr),
        .wr_target (upd_target)
    );

    bp_next_sel #(
        .PC_W (PC_W)
    ) u_sel (
        .hit     (pred_hit),
        .taken   (pred_taken),
        .pc      (fetch_pc),
        .target  (target_rd),
        .next_pc (pred_next_pc)
    );

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int PC_W    = 32,
    parameter int CTR_W   = 2,
    parameter bit HAS_BTB = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic [PC_W-1:0] target_rd,
    input logic [CTR_W-1:0] fetch_ctr,
    input logic [CTR_W-1:0] upd_ctr,
    input logic            upd_hit,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target
);

    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] WEAK_T  = CTR_W'(1) << (CTR_W - 1);
    localparam logic [CTR_W-1:0] WEAK_NT = WEAK_T - CTR_W'(1);

    // R5: a taken hit steers fetch to the stored target
    assert_target_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (pred_hit && pred_taken) |-> (pred_next_pc == target_rd));

    // R5: every other case falls through
    assert_fall_through_R5: assert property (@(posedge clk) disable iff (rst)
        !(pred_hit && pred_taken) |-> (pred_next_pc == fetch_pc + PC_W'(4)));

    // R6: first cycle out of reset shows empty store and weak not-taken counters
    assert_reset_state_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_hit && !pred_taken && fetch_ctr == WEAK_NT));

    // R7: a taken miss allocates and predicts its own target next cycle
    assert_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        (HAS_BTB && upd_valid && !upd_hit && upd_taken) ##1 (fetch_pc == $past(upd_pc))
        |-> (pred_hit && pred_taken && pred_next_pc == $past(upd_target)));

    // R7: a not-taken miss allocates nothing
    assert_no_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_hit && !upd_taken) ##1 (fetch_pc == $past(upd_pc))
        |-> !pred_hit);

    // R2: counter holds at the top on a taken hit
    assert_sat_high_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_hit && upd_taken && upd_ctr == CTR_MAX) ##1 (fetch_pc == $past(upd_pc))
        |-> (fetch_ctr == CTR_MAX));

    // R2: counter holds at zero on a not-taken resolve
    assert_sat_low_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && upd_ctr == '0) ##1 (fetch_pc == $past(upd_pc))
        |-> (fetch_ctr == '0));

    // R9: nothing changes for a slot while no resolve is presented
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid) ##1 (fetch_pc == $past(fetch_pc) && !$past(rst))
        |-> (fetch_ctr == $past(fetch_ctr) && pred_hit == $past(pred_hit)));

endmodule

bind bimodal_btb_predictor bp_checker #(
    .PC_W    (PC_W),
    .CTR_W   (CTR_W),
    .HAS_BTB (HAS_BTB)
) u_bp_checker (
    .clk          (clk),
    .rst          (rst),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .target_rd    (target_rd),
    .fetch_ctr    (fetch_ctr),
    .upd_ctr      (upd_ctr),
    .upd_hit      (upd_hit),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target)
);

// File: tb/tb_bimodal_btb_predictor.sv
module tb_bimodal_btb_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 16;
    localparam int ENTRIES    = 8;
    localparam int CTR_W      = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_hit;
    logic            pred_taken;
    logic [PC_W-1:0] pred_next_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;

    int checks   = 0;
    int failures = 0;

    // Bench model of slot contents, built from the requirements.
    int          m_ctr [ENTRIES];
    logic        m_val [ENTRIES];
    logic [10:0] m_tag [ENTRIES];
    logic [15:0] m_tgt [ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    bimodal_btb_predictor #(
        .PC_W    (PC_W),
        .ENTRIES (ENTRIES),
        .CTR_W   (CTR_W),
        .HAS_BTB (1'b1)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_taken   (pred_taken),
        .pred_next_pc (pred_next_pc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_target   (upd_target)
    );

    function automatic logic [15:0] mk_pc(input int tag, input int idx);
        return {11'(tag), 3'(idx), 2'b00};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            m_ctr[i] = 1;
            m_val[i] = 1'b0;
            m_tag[i] = '0;
            m_tgt[i] = '0;
        end
    endtask

    task automatic model_update(input logic [15:0] pc, input logic tk, input logic [15:0] tgt);
        int i = int'(pc[4:2]);
        logic hit = m_val[i] && (m_tag[i] == pc[15:5]);
        if (hit) begin
            if (tk) begin
                m_ctr[i] = (m_ctr[i] == 3) ? 3 : m_ctr[i] + 1;
                m_tgt[i] = tgt;
            end else begin
                m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
            end
        end else if (tk) begin
            m_val[i] = 1'b1;
            m_tag[i] = pc[15:5];
            m_tgt[i] = tgt;
            m_ctr[i] = 2;
        end else begin
            m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
        end
    endtask

    task automatic check_pc(input logic [15:0] pc, input string req);
        int          i;
        logic        ehit;
        logic        etk;
        logic [15:0] enext;
        fetch_pc = pc;
        #1;
        i     = int'(pc[4:2]);
        ehit  = m_val[i] && (m_tag[i] == pc[15:5]);
        etk   = (m_ctr[i] >= 2);
        enext = (ehit && etk) ? m_tgt[i] : pc + 16'd4;
        checks++;
        if (pred_hit !== ehit || pred_taken !== etk || pred_next_pc !== enext) begin
            failures++;
            $display("FAIL %s pc=%h got hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
                     req, pc, pred_hit, pred_taken, pred_next_pc, ehit, etk, enext);
        end
    endtask

    task automatic check_all(input string req);
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                check_pc(mk_pc(t, i), req);
            end
        end
    endtask

    task automatic do_update(input logic [15:0] pc, input logic tk, input logic [15:0] tgt);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_target = tgt;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(pc, tk, tgt);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [15:0] p1;
        logic [15:0] lf;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R6: empty store, weak not-taken everywhere
        check_all("R6");

        // R3 and R1: walk slot 1 through all counter states
        p1 = mk_pc(5, 1);
        do_update(p1, 1'b1, 16'h1230);   // miss, taken: allocate to 10 (R7)
        check_pc(p1, "R7");
        do_update(p1, 1'b0, 16'h0000);   // 01
        check_pc(p1, "R1");
        do_update(p1, 1'b0, 16'h0000);   // 00
        check_pc(p1, "R1");
        do_update(p1, 1'b0, 16'h0000);   // stays 00
        check_pc(p1, "R2");
        do_update(p1, 1'b1, 16'h2340);   // 01, still not taken
        check_pc(p1, "R3");
        do_update(p1, 1'b1, 16'h2340);   // 10, taken to new target
        check_pc(p1, "R3");
        do_update(p1, 1'b1, 16'h3450);   // 11, target refreshed (R7)
        check_pc(p1, "R7");
        do_update(p1, 1'b1, 16'h3450);   // stays 11
        check_pc(p1, "R2");
        do_update(p1, 1'b0, 16'h7770);   // 10, still taken, target kept
        check_pc(p1, "R3");

        // R4: other tag on slot 1 shares the counter but misses
        check_pc(mk_pc(6, 1), "R4");

        // R7: not-taken miss on slot 3 allocates nothing
        do_update(mk_pc(2, 3), 1'b0, 16'h4440);
        check_pc(mk_pc(2, 3), "R7");

        // R5: fall-through wraps at the top of the address space
        check_pc(16'hFFFC, "R5");
        do_update(16'hFFFC, 1'b1, 16'h0100);
        check_pc(16'hFFFC, "R5");

        // R8: fetch and resolve on slot 2 in the same cycle
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = mk_pc(1, 2);
        upd_taken  = 1'b1;
        upd_target = 16'h5550;
        check_pc(mk_pc(1, 2), "R8");
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(mk_pc(1, 2), 1'b1, 16'h5550);
        check_pc(mk_pc(1, 2), "R8");

        // R9: resolve fields wiggle with upd_valid low
        @(negedge clk);
        upd_valid  = 1'b0;
        upd_pc     = mk_pc(0, 4);
        upd_taken  = 1'b1;
        upd_target = 16'h6660;
        repeat (2) @(posedge clk);
        #1;
        check_all("R9");

        // R2 R4 R5 R7: pseudo-random resolve stream over two tags
        lf = 16'hACE1;
        for (int s = 0; s < 400; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_update(mk_pc(int'(lf[3]), int'(lf[2:0])), lf[4] | lf[5],
                      {lf[15:2] ^ 14'h1a5, 2'b00});
            check_all("R2_R4_R5_R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule